// File: doc/BRIEF.md
# Single-Wire Bus Transmitter with Conflict Detection

This block serializes one data word onto a line that several transmitters share. A frame is a low start bit, nine data bits sent least significant bit first, and a high stop bit. Each pulse of the transfer-clock enable moves the frame forward by one bit. The block reads the level on the shared line back through a two-flop synchronizer. At each sample point it compares that level with the level it is driving. A mismatch means another node has won the bus. The block then raises a sticky interrupt request and, if enabled, drops its own transmit enable and abandons the frame.

Four mode inputs select the behaviour. The first picks the sample point: every transfer-clock pulse, or an external strobe that stands in for a one-shot timer underflow. The second lets a conflict clear the transmit enable automatically. The third picks the start trigger: the next transfer-clock pulse, or an edge on the receive line. The fourth picks the polarity of that edge. The baud generator, the timer and the receive path are outside this block.

Top module: `conflict_tx`

## Requirements
- R1: After reset, txd is 1 and irq, te and busy are 0.
- R2: A frame drives 0 for the start bit, then wr_data bits 0 to 8 in that order, then 1 for the stop bit. The frame advances one bit per tick pulse. txd is 1 whenever busy is 0.
- R3: With start_on_rx = 0, the start bit appears on txd after the first tick that arrives while te = 1 and a word is held. No frame starts while te = 0.
- R4: With start_on_rx = 1 and rx_inv = 0, a frame starts on a falling edge of the synchronized rxd, without waiting for tick. tick pulses alone do not start it.
- R5: With start_on_rx = 1 and rx_inv = 1, a rising edge of rxd starts the frame and a falling edge is ignored.
- R6: With samp_tmr = 0, during a frame, a tick pulse at which the synchronized rxd differs from txd sets irq.
- R7: With samp_tmr = 1, the comparison happens only on tmr_stb. tick pulses cause no comparison.
- R8: irq stays 1 until a pulse on irq_clr clears it.
- R9: With auto_off = 1, a conflict clears te, ends the frame, returns txd to 1 and drops busy. With auto_off = 0, te stays set and the frame completes.
- R10: busy is 1 while a word is held or a frame is in progress. A wr_stb while busy = 1 is ignored.
- R11: A mismatch between rxd and txd outside a frame never sets irq.
- R12: A te_wr pulse loads te_wdata into te.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Transfer-clock enable: one bit time per pulse |
| wr_stb | input | 1 | Loads wr_data when not busy |
| wr_data | input | 9 | Word to send |
| te_wr | input | 1 | Write strobe for the transmit enable |
| te_wdata | input | 1 | Value written into te |
| irq_clr | input | 1 | Write-one-to-clear for irq |
| tmr_stb | input | 1 | External sample strobe (timer underflow) |
| rxd | input | 1 | Level read back from the shared line |
| samp_tmr | input | 1 | 1: sample on tmr_stb; 0: sample on tick |
| auto_off | input | 1 | 1: a conflict clears te and aborts the frame |
| start_on_rx | input | 1 | 1: start on an rxd edge; 0: start on tick |
| rx_inv | input | 1 | 1: the start edge is rising; 0: falling |
| txd | output | 1 | Serial output, idle high |
| irq | output | 1 | Sticky conflict interrupt request |
| te | output | 1 | Current transmit enable |
| busy | output | 1 | A word is held or a frame is running |

## Verification
The bench sends two data words with different bit patterns through a loopback line. A bit-order or stop-bit error therefore shows as a wrong bit, and a false conflict shows on irq. It starts frames on a tick, on a falling edge and on a rising edge. In each edge case it first applies the edge of the wrong polarity, which separates a correct edge trigger from one that fires on any transition. It forces the line low while a high bit is being driven. This is done with the tick sample point and again with the strobe sample point, and with auto-clear both on and off. The results separate the two sample points, show whether the frame is abandoned, and show whether irq holds until it is cleared. It also drives a mismatch while no frame is running and writes words while the block is busy. Both must have no effect.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int unsigned FRAME_DATA_W   = 9;
    localparam int unsigned RX_SYNC_STAGES = 2;

    typedef struct packed {
        logic samp_tmr;
        logic auto_off;
        logic start_on_rx;
        logic rx_inv;
    } ctx_mode_t;
endpackage

// File: rtl/ctx_sync.sv
module ctx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d[0] = rxd_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
        prev_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ctx_cmp.sv
module ctx_cmp (
    input  logic             tick_i,
    input  logic             tmr_stb_i,
    input  ctx_pkg::ctx_mode_t mode_i,
    input  logic             sending_i,
    input  logic             txd_i,
    input  logic             rx_lvl_i,
    output logic             conflict_o
);
    logic sample_pt;

    always_comb begin
        sample_pt  = mode_i.samp_tmr ? tmr_stb_i : tick_i;
        conflict_o = sending_i & sample_pt & (txd_i ^ rx_lvl_i);
    end
endmodule

// File: rtl/ctx_core.sv
module ctx_core #(
    parameter int unsigned DATA_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_stb_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               te_wr_i,
    input  logic               te_val_i,
    input  logic               irq_clr_i,
    input  ctx_pkg::ctx_mode_t mode_i,
    input  logic               rx_rise_i,
    input  logic               rx_fall_i,
    input  logic               conflict_i,
    output logic               txd_o,
    output logic               irq_o,
    output logic               te_o,
    output logic               busy_o,
    output logic               sending_o
);
    localparam int unsigned STOP_IDX = DATA_W + 1;
    localparam int unsigned IDX_W    = $clog2(STOP_IDX + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STOP_IDX);

    typedef struct packed {
        logic              sending;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] hold;
        logic              loaded;
        logic              te;
        logic              txd;
        logic              irq;
    } core_t;

    core_t st_d, st_q;
    logic  trig_edge;
    logic  go;
    logic  busy_w;

    always_comb begin
        st_d      = st_q;
        busy_w    = st_q.loaded | st_q.sending;
        trig_edge = mode_i.rx_inv ? rx_rise_i : rx_fall_i;
        go        = st_q.te & st_q.loaded & ~st_q.sending &
                    (mode_i.start_on_rx ? trig_edge : tick_i);

        if (te_wr_i) begin
            st_d.te = te_val_i;
        end
        if (wr_stb_i && !busy_w) begin
            st_d.hold   = wr_data_i;
            st_d.loaded = 1'b1;
        end

        if (go) begin
            st_d.sending = 1'b1;
            st_d.idx     = '0;
            st_d.shreg   = st_q.hold;
            st_d.loaded  = 1'b0;
            st_d.txd     = 1'b0;
        end else if (st_q.sending && tick_i) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.sending = 1'b0;
                st_d.idx     = '0;
                st_d.txd     = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
                if (st_q.idx + 1'b1 == LAST_IDX) begin
                    st_d.txd = 1'b1;
                end else begin
                    st_d.txd   = st_q.shreg[0];
                    st_d.shreg = st_q.shreg >> 1;
                end
            end
        end

        if (irq_clr_i) begin
            st_d.irq = 1'b0;
        end
        if (conflict_i) begin
            st_d.irq = 1'b1;
            if (mode_i.auto_off) begin
                st_d.te      = 1'b0;
                st_d.sending = 1'b0;
                st_d.idx     = '0;
                st_d.txd     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.txd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd_o     = st_q.txd;
    assign irq_o     = st_q.irq;
    assign te_o      = st_q.te;
    assign busy_o    = st_q.loaded | st_q.sending;
    assign sending_o = st_q.sending;
endmodule

// File: rtl/conflict_tx.sv
module conflict_tx #(
    parameter int unsigned DATA_W      = ctx_pkg::FRAME_DATA_W,
    parameter int unsigned SYNC_STAGES = ctx_pkg::RX_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              te_wr,
    input  logic              te_wdata,
    input  logic              irq_clr,
    input  logic              tmr_stb,
    input  logic              rxd,
    input  logic              samp_tmr,
    input  logic              auto_off,
    input  logic              start_on_rx,
    input  logic              rx_inv,
    output logic              txd,
    output logic              irq,
    output logic              te,
    output logic              busy
);
    ctx_pkg::ctx_mode_t mode;
    logic rx_lvl, rx_rise, rx_fall;
    logic sending, conflict;

    assign mode = '{samp_tmr: samp_tmr, auto_off: auto_off,
                    start_on_rx: start_on_rx, rx_inv: rx_inv};

    ctx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rxd_i  (rxd),
        .lvl_o  (rx_lvl),
        .rise_o (rx_rise),
        .fall_o (rx_fall)
    );

    ctx_cmp u_cmp (
        .tick_i     (tick),
        .tmr_stb_i  (tmr_stb),
        .mode_i     (mode),
        .sending_i  (sending),
        .txd_i      (txd),
        .rx_lvl_i   (rx_lvl),
        .conflict_o (conflict)
    );

    ctx_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .wr_stb_i   (wr_stb),
        .wr_data_i  (wr_data),
        .te_wr_i    (te_wr),
        .te_val_i   (te_wdata),
        .irq_clr_i  (irq_clr),
        .mode_i     (mode),
        .rx_rise_i  (rx_rise),
        .rx_fall_i  (rx_fall),
        .conflict_i (conflict),
        .txd_o      (txd),
        .irq_o      (irq),
        .te_o       (te),
        .busy_o     (busy),
        .sending_o  (sending)
    );
endmodule

// File: rtl/ctx_checker.sv
module ctx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic start_on_rx,
    input logic rx_inv,
    input logic auto_off,
    input logic irq_clr,
    input logic txd,
    input logic irq,
    input logic te,
    input logic busy,
    input logic sending,
    input logic conflict,
    input logic rx_rise,
    input logic rx_fall
);
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    assert_tick_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sending) && !$past(start_on_rx)) |-> $past(tick));

    assert_edge_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sending) && $past(start_on_rx)) |-> $past(rx_inv ? rx_rise : rx_fall));

    assert_conflict_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> irq);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conflict && auto_off) |=> (!te && txd && !busy));

    assert_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> sending);
endmodule

bind conflict_tx ctx_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start_on_rx (start_on_rx),
    .rx_inv      (rx_inv),
    .auto_off    (auto_off),
    .irq_clr     (irq_clr),
    .txd         (txd),
    .irq         (irq),
    .te          (te),
    .busy        (busy),
    .sending     (sending),
    .conflict    (conflict),
    .rx_rise     (rx_rise),
    .rx_fall     (rx_fall)
);

// File: tb/conflict_tx_tb.sv
module conflict_tx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 9;
    localparam int TGAP       = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 0, wr_stb = 0, te_wr = 0, te_wdata = 0, irq_clr = 0, tmr_stb = 0;
    logic [DW-1:0] wr_data = '0;
    logic samp_tmr = 0, auto_off = 0, start_on_rx = 0, rx_inv = 0;
    logic lb = 1'b1, jam = 1'b0, rx_drv = 1'b1;
    logic rxd, txd, irq, te, busy;
    int   n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    assign rxd = lb ? (txd & ~jam) : rx_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    conflict_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stb(wr_stb), .wr_data(wr_data),
        .te_wr(te_wr), .te_wdata(te_wdata), .irq_clr(irq_clr), .tmr_stb(tmr_stb),
        .rxd(rxd), .samp_tmr(samp_tmr), .auto_off(auto_off),
        .start_on_rx(start_on_rx), .rx_inv(rx_inv),
        .txd(txd), .irq(irq), .te(te), .busy(busy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (TGAP) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_word(input logic [DW-1:0] d);
        @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic set_te(input logic v);
        @(negedge clk) begin te_wr = 1'b1; te_wdata = v; end
        @(negedge clk) te_wr = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk) irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        @(negedge clk);
    endtask

    // Frame body: optional start-bit tick, data bits, stop bit, return to idle.
    task automatic frame_body(input logic [DW-1:0] d, input logic started);
        if (!started) begin
            pulse_tick();
            chk("R2 start bit", txd, 0);
        end
        write_word(~d);   // ignored: frame running
        for (int i = 0; i < DW; i++) begin
            pulse_tick();
            chk($sformatf("R2 data bit %0d", i), txd, d[i]);
        end
        pulse_tick();
        chk("R2 stop bit", txd, 1);
        pulse_tick();
        chk("R10 busy low after frame, mid-frame write dropped", busy, 0);
        chk("R2 idle high", txd, 1);
        pulse_tick();
        chk("R10 no second frame", txd, 1);
    endtask

    task automatic t_reset();
        chk("R1 txd", txd, 1);
        chk("R1 irq", irq, 0);
        chk("R1 te", te, 0);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_te_gate();
        write_word(9'h1A5);
        chk("R10 busy with word held", busy, 1);
        write_word(9'h0F0);   // ignored: word already held
        pulse_tick();
        pulse_tick();
        chk("R3 no frame while te=0", txd, 1);
        set_te(1'b1);
        chk("R12 te set", te, 1);
        chk("R3 no start before tick", txd, 1);
        frame_body(9'h1A5, 1'b0);
        chk("R6 no false conflict in loopback", irq, 0);
    endtask

    task automatic t_second_pattern();
        write_word(9'h05A);
        frame_body(9'h05A, 1'b0);
        chk("R6 no false conflict pattern 2", irq, 0);
        set_te(1'b0);
        chk("R12 te cleared", te, 0);
    endtask

    task automatic t_edge_start(input logic inv);
        lb = 1'b0; samp_tmr = 1'b1; start_on_rx = 1'b1; rx_inv = inv;
        rx_drv = inv;                 // level reached after the active edge
        wait_cyc(6);
        write_word(9'h133);
        set_te(1'b1);
        pulse_tick();
        pulse_tick();
        chk(inv ? "R5 ticks do not start" : "R4 ticks do not start", txd, 1);
        rx_drv = ~inv;                // wrong-polarity edge
        wait_cyc(6);
        chk(inv ? "R5 falling edge ignored" : "R4 rising edge ignored", txd, 1);
        chk(inv ? "R5 still busy" : "R4 still busy", busy, 1);
        rx_drv = inv;                 // active edge
        wait_cyc(6);
        chk(inv ? "R5 rising edge starts" : "R4 falling edge starts", txd, 0);
        frame_body(9'h133, 1'b1);
        set_te(1'b0);
        start_on_rx = 1'b0; rx_inv = 1'b0; samp_tmr = 1'b0;
        rx_drv = 1'b1; wait_cyc(6); lb = 1'b1;
    endtask

    task automatic t_conflict_tick(input logic ao);
        samp_tmr = 1'b0; auto_off = ao;
        write_word(9'h1FF);
        set_te(1'b1);
        pulse_tick();              // start bit
        pulse_tick();              // D0 = 1
        jam = 1'b1;
        wait_cyc(4);
        chk("R6 no irq between ticks", irq, 0);
        pulse_tick();              // sample sees mismatch
        chk("R6 irq on tick conflict", irq, 1);
        jam = 1'b0;
        if (ao) begin
            chk("R9 te auto-cleared", te, 0);
            chk("R9 frame aborted", busy, 0);
            chk("R9 txd idle", txd, 1);
        end else begin
            chk("R9 te kept", te, 1);
            chk("R9 frame continues", busy, 1);
            repeat (9) pulse_tick();
            chk("R9 frame completed", busy, 0);
            set_te(1'b0);
        end
        chk("R8 irq held", irq, 1);
        clear_irq();
        chk("R8 irq cleared", irq, 0);
        auto_off = 1'b0;
    endtask

    task automatic t_timer();
        samp_tmr = 1'b1;
        write_word(9'h1FF);
        set_te(1'b1);
        pulse_tick();
        pulse_tick();
        jam = 1'b1;
        wait_cyc(4);
        pulse_tick();
        pulse_tick();
        chk("R7 ticks do not sample", irq, 0);
        @(negedge clk) tmr_stb = 1'b1;
        @(negedge clk) tmr_stb = 1'b0;
        chk("R7 strobe samples", irq, 1);
        jam = 1'b0;
        repeat (8) pulse_tick();
        chk("R7 frame done", busy, 0);
        clear_irq();
        set_te(1'b0);
        samp_tmr = 1'b0;
    endtask

    task automatic t_idle_mismatch();
        lb = 1'b0; rx_drv = 1'b0;
        wait_cyc(4);
        pulse_tick();
        @(negedge clk) tmr_stb = 1'b1;
        @(negedge clk) tmr_stb = 1'b0;
        samp_tmr = 1'b1;
        @(negedge clk) tmr_stb = 1'b1;
        @(negedge clk) tmr_stb = 1'b0;
        wait_cyc(2);
        chk("R11 no irq outside frame", irq, 0);
        samp_tmr = 1'b0; rx_drv = 1'b1; wait_cyc(4); lb = 1'b1;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_te_gate();
        t_second_pattern();
        t_edge_start(1'b0);
        t_edge_start(1'b1);
        t_conflict_tick(1'b1);
        t_conflict_tick(1'b0);
        t_timer();
        t_idle_mismatch();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule